// File: doc/BRIEF.md
# Two-Input Pulse-Pattern Recognizer

This block is a small Moore state machine. It watches two level inputs, `x1` and `x0`, and raises a single flag `z` once a set pattern has appeared on them. The pattern is the input pair going from 00 to 01 and then back to 00. The flag then stays set while the inputs stay at 00. It clears as soon as `x1` rises alone, which gives the code 10. The machine is the clocked counterpart of a fundamental-mode asynchronous flow table that has been reduced to three states. The inputs are taken as already synchronized, and the input pair is sampled on every rising clock edge.

The stable states use the codes idle = 00, armed = 01 and hit = 10. When the machine moves from armed to hit, it does not jump there directly. It passes for one clock through the otherwise unused code 11, so that only one state bit changes at each step. The flag is the high state bit. For observation, the 2-bit state is brought out on `q`.

Top module: `pulse_pattern_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, that edge loads state 00 into `q`, and `z` reads 0 afterwards.
- R2: In state 00, input code 01 (x1=0, x0=1) moves the machine to 01. Codes 00, 10 and 11 keep it in 00.
- R3: In state 01, input code 01 keeps the machine in 01, and code 11 returns it to 00.
- R4: In state 01, input code 00 moves the machine to the bridge code 11. From 11 the next edge always moves it to 10, whatever the input code.
- R5: In state 10, input code 00 keeps the machine in 10, and code 10 returns it to 00.
- R6: An input code with no defined move in the current state leaves the state unchanged: code 10 in state 01, and codes 01 or 11 in state 10.
- R7: `z` equals bit 1 of `q`. It is 1 in states 10 and 11 and 0 in states 00 and 01.
- R8: Starting from reset, `z` rises only after the code sequence 00, 01, 00. It stays 1 while 00 is repeated, and it is 0 once 10 has been applied and then 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| x1 | input | 1 | High bit of the input code, already synchronized |
| x0 | input | 1 | Low bit of the input code, already synchronized |
| z | output | 1 | Pattern-detected flag |
| q | output | 2 | Current state code |

## Verification
The assertions take `x1` and `x0` to be clean levels that change only between rising edges. They also take the reset to be applied synchronously. Beyond that, they place no limit on which input code may follow which, so the checks on the bridge step and on the held states must hold for every input code. The bench drives each input code and the reset on the falling edge. It samples the outputs on the next falling edge. It applies every one of the four codes in each stable state and also while the machine sits in the bridge code, so each code stays a legal, settled level when the machine samples it.

// File: rtl/pp_fsm_pkg.sv
package pp_fsm_pkg;

    localparam int STATE_W = 2;
    localparam int CODE_W  = 2;

    // State codes; the bridge code sits between armed and hit so every
    // step flips a single bit.
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'b00,
        ST_ARMED  = 2'b01,
        ST_BRIDGE = 2'b11,
        ST_HIT    = 2'b10
    } pp_state_e;

    // Input code {x1, x0}.
    typedef enum logic [CODE_W-1:0] {
        IN_LL = 2'b00,
        IN_LH = 2'b01,
        IN_HH = 2'b11,
        IN_HL = 2'b10
    } pp_code_e;

    typedef struct packed {
        pp_state_e state;
    } pp_regs_t;

endpackage

// File: rtl/pp_next_state.sv
module pp_next_state
    import pp_fsm_pkg::*;
(
    input  pp_state_e cur_state,
    input  pp_code_e  in_code,
    output pp_state_e nxt_state
);

    always_comb begin
        nxt_state = cur_state;  // undefined entries hold
        unique case (cur_state)
            ST_IDLE: begin
                if (in_code == IN_LH) nxt_state = ST_ARMED;
            end
            ST_ARMED: begin
                unique case (in_code)
                    IN_LL:   nxt_state = ST_BRIDGE;
                    IN_HH:   nxt_state = ST_IDLE;
                    default: nxt_state = ST_ARMED;
                endcase
            end
            ST_BRIDGE: begin
                nxt_state = ST_HIT;
            end
            ST_HIT: begin
                if (in_code == IN_HL) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

endmodule

// File: rtl/pp_output_decode.sv
module pp_output_decode
    import pp_fsm_pkg::*;
(
    input  pp_state_e          cur_state,
    output logic               flag,
    output logic [STATE_W-1:0] state_code
);

    always_comb begin
        state_code = cur_state;
        flag       = cur_state[STATE_W-1];
    end

endmodule

// File: rtl/pulse_pattern_fsm.sv
module pulse_pattern_fsm
    import pp_fsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       x1,
    input  logic       x0,
    output logic       z,
    output logic [1:0] q
);

    pp_regs_t  regs_d;
    pp_regs_t  regs_q;
    pp_state_e step_state;
    pp_code_e  code;

    assign code = pp_code_e'({x1, x0});

    pp_next_state u_next (
        .cur_state (regs_q.state),
        .in_code   (code),
        .nxt_state (step_state)
    );

    always_comb begin
        regs_d.state = step_state;
        if (!rst_n) regs_d.state = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    pp_output_decode u_out (
        .cur_state  (regs_q.state),
        .flag       (z),
        .state_code (q)
    );

endmodule

// File: rtl/pp_fsm_checker.sv
module pp_fsm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       x1,
    input logic       x0,
    input logic       z,
    input logic [1:0] q
);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (q == 2'b00 && !z));

    assert_idle_holds_high_x1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q == 2'b00 && x1) |=> (q == 2'b00));

    assert_armed_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q == 2'b01 && x1 && x0) |=> (q == 2'b00));

    assert_bridge_to_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q == 2'b11) |=> (q == 2'b10));

    assert_hit_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q == 2'b10 && x1 && !x0) |=> (q == 2'b00));

    assert_hit_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q == 2'b10 && x0) |=> (q == 2'b10));

    assert_armed_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q == 2'b01 && x1 && !x0) |=> (q == 2'b01));

    assert_flag_high_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        z == q[1]);

    assert_rise_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(z) |-> ($past(q) == 2'b01 && $past({x1, x0}) == 2'b00));

endmodule

bind pulse_pattern_fsm pp_fsm_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x1    (x1),
    .x0    (x0),
    .z     (z),
    .q     (q)
);

// File: tb/tb_pulse_pattern_fsm.sv
module tb_pulse_pattern_fsm;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x1 = 1'b0;
    logic       x0 = 1'b0;
    logic       z;
    logic [1:0] q;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    pulse_pattern_fsm dut (
        .clk(clk), .rst_n(rst_n), .x1(x1), .x0(x0), .z(z), .q(q)
    );

    task automatic check(input string tag, input logic [1:0] eq, input logic ez);
        checks++;
        if (q !== eq || z !== ez) begin
            errors++;
            $display("FAIL %s: q=%b z=%b expected q=%b z=%b", tag, q, z, eq, ez);
        end
    endtask

    // Apply a code at the falling edge, let one rising edge pass, return at next falling edge.
    task automatic step(input logic [1:0] code);
        {x1, x0} = code;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        {x1, x0} = 2'b00;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic go_armed();
        do_reset();
        step(2'b01);
    endtask

    task automatic go_hit();
        go_armed();
        step(2'b00);
        step(2'b00);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 after reset", 2'b00, 1'b0);
        go_hit();
        rst_n = 1'b0;
        step(2'b00);
        check("R1 reset from hit", 2'b00, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_idle();
        do_reset();
        step(2'b00); check("R2 idle on 00", 2'b00, 1'b0);
        step(2'b10); check("R2 idle on 10", 2'b00, 1'b0);
        step(2'b11); check("R2 idle on 11", 2'b00, 1'b0);
        step(2'b01); check("R2 idle to armed on 01", 2'b01, 1'b0);
    endtask

    task automatic t_armed();
        go_armed();
        step(2'b01); check("R3 armed holds on 01", 2'b01, 1'b0);
        step(2'b10); check("R6 armed holds on 10", 2'b01, 1'b0);
        step(2'b11); check("R3 armed to idle on 11", 2'b00, 1'b0);
    endtask

    task automatic t_bridge();
        for (int c = 0; c < 4; c++) begin
            go_armed();
            step(2'b00);
            check("R4 armed to bridge on 00", 2'b11, 1'b1);
            step(c[1:0]);
            check("R4 bridge to hit", 2'b10, 1'b1);
        end
    endtask

    task automatic t_hit();
        go_hit();
        check("R7 flag in hit", 2'b10, 1'b1);
        step(2'b00); check("R5 hit holds on 00", 2'b10, 1'b1);
        step(2'b01); check("R6 hit holds on 01", 2'b10, 1'b1);
        step(2'b11); check("R6 hit holds on 11", 2'b10, 1'b1);
        step(2'b10); check("R5 hit to idle on 10", 2'b00, 1'b0);
    endtask

    task automatic t_sequence();
        do_reset();
        step(2'b00); check("R8 no flag after 00", 2'b00, 1'b0);
        step(2'b01); check("R8 no flag after 00,01", 2'b01, 1'b0);
        step(2'b00); check("R8 flag after 00,01,00", 2'b11, 1'b1);
        for (int i = 0; i < 3; i++) begin
            step(2'b00); check("R8 flag held on repeated 00", 2'b10, 1'b1);
        end
        step(2'b10); check("R8 flag clear after 10", 2'b00, 1'b0);
        step(2'b00); check("R8 flag clear after 10,00", 2'b00, 1'b0);
        // Aborted pattern: 01 then 11 must not raise the flag.
        step(2'b01);
        step(2'b11);
        step(2'b00); check("R8 no flag after aborted pattern", 2'b00, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_armed();
        t_bridge();
        t_hit();
        t_sequence();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule